// File: doc/BRIEF.md
# Integer Negate Execution Unit

This unit takes one decoded single-operand negate request per cycle and returns the two's complement of the operand at 8, 16, 32 or 64 bits. The operand width is not fixed. It is chosen from the primary opcode byte, the operand-size override, the 64-bit-wide prefix and the 64-bit mode flag. Alongside the result, the unit produces the full set of arithmetic status flags. Carry follows a special rule: it reports whether the operand was nonzero.

A request is taken on `in_valid` and answered one cycle later. On a normal answer, `out_valid` pulses with the result and flags. If a locked request targets a register, `ud_fault` pulses instead, and the result and flags keep their old values. Requests whose opcode or ModRM reg extension does not select negate are ignored. For byte operations in 64-bit mode with an extension prefix present, the unit reports that register codes 4 to 7 name the low bytes of those registers rather than the legacy high bytes.

Top module: `neg_exec_unit`

## Requirements
- R1: On an accepted request, `result` equals 0 minus the operand taken at the selected width. All bits above that width are zero.
- R2: The width is selected as follows:
  - Opcode 0xF6 with `modrm_reg`=3 selects 8 bits.
  - Opcode 0xF7 with `modrm_reg`=3 selects 32 bits by default, or 16 bits with `pfx_opsz`.
  - When `long_mode`=1, `pfx_rexw` selects 64 bits and wins over `pfx_opsz`.
  - When `long_mode`=0, `pfx_rex` and `pfx_rexw` have no effect.
- R3: `cf` is 0 when the operand at the selected width is zero, and 1 otherwise.
- R4: `of` is 1 only when the operand is the most negative value at the selected width. In that case `result` equals the operand.
- R5: `sf` is the top bit of the result at the selected width. `zf` is 1 exactly when that result is zero.
- R6: `af` is 1 when the low four bits of the operand are nonzero. `pf` is 1 when the low 8 bits of the result hold an even number of ones.
- R7: `result`, the flags and `out_valid` appear on the clock edge after the edge that samples `in_valid`. `out_valid` is a single-cycle pulse per request.
- R8: A negate request with `pfx_lock`=1 and `dst_is_mem`=0 pulses `ud_fault` in the response cycle. In that cycle `out_valid` stays 0, and `result` and the flags keep their previous values. A locked request with a memory destination completes normally.
- R9: A request whose opcode is neither 0xF6 nor 0xF7, or whose `modrm_reg` is not 3, raises neither `out_valid` nor `ud_fault`, and `result` is unchanged.
- R10: `low_byte_sel` is 1 with a completed result only when all of the following hold: the operation is a byte operation, `long_mode`=1, `pfx_rex`=1, `dst_is_mem`=0, and `rm_code` is in 4..7. Otherwise it is 0.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 8 | Primary opcode byte |
| modrm_reg | input | 3 | ModRM reg field (opcode extension) |
| rm_code | input | 3 | ModRM r/m register code |
| pfx_rex | input | 1 | Any 64-bit extension prefix present |
| pfx_rexw | input | 1 | Extension prefix with the wide-operand bit set |
| pfx_opsz | input | 1 | Operand-size override present |
| pfx_lock | input | 1 | LOCK prefix present |
| long_mode | input | 1 | Core runs in 64-bit mode |
| dst_is_mem | input | 1 | Destination is memory (1) or register (0) |
| operand | input | 64 | Operand value |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Negated value, zero above the selected width |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag |
| sf | output | 1 | Sign flag |
| zf | output | 1 | Zero flag |
| af | output | 1 | Auxiliary carry flag |
| pf | output | 1 | Parity flag |
| ud_fault | output | 1 | Invalid-opcode fault pulse |
| low_byte_sel | output | 1 | Byte register codes 4..7 mean low bytes |

## Verification
The assertions assume that a request is presented for exactly one cycle and that the prefix and mode inputs are stable while `in_valid` is high. The stimulus keeps to this by driving every request between falling edges and dropping `in_valid` before the next one. Requests are never issued back to back, so each response can be examined in isolation. The hold checks also assume that nothing but a negate request changes the outputs, and the stimulus inserts only idle cycles or non-negate requests between the probes.

// File: rtl/neg_exec_unit.sv
module neg_exec_unit #(
  parameter logic [7:0] OPC_BYTE = 8'hF6,
  parameter logic [7:0] OPC_WIDE = 8'hF7,
  parameter logic [2:0] NEG_EXT  = 3'd3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  opcode,
  input  logic [2:0]  modrm_reg,
  input  logic [2:0]  rm_code,
  input  logic        pfx_rex,
  input  logic        pfx_rexw,
  input  logic        pfx_opsz,
  input  logic        pfx_lock,
  input  logic        long_mode,
  input  logic        dst_is_mem,
  input  logic [63:0] operand,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        cf,
  output logic        of,
  output logic        sf,
  output logic        zf,
  output logic        af,
  output logic        pf,
  output logic        ud_fault,
  output logic        low_byte_sel
);

  localparam int DW = 64;

  typedef enum logic [1:0] {SZ8, SZ16, SZ32, SZ64} size_t;

  logic        is_byte, is_wide, is_neg, lock_bad, take, trap;
  size_t       sz;
  logic [DW-1:0] mask, opnd_m, res_m;
  logic        opnd_top, res_top;

  assign is_byte  = opcode == OPC_BYTE;
  assign is_wide  = opcode == OPC_WIDE;
  assign is_neg   = (is_byte || is_wide) && (modrm_reg == NEG_EXT);
  assign lock_bad = pfx_lock && !dst_is_mem;
  assign take     = in_valid && is_neg && !lock_bad;
  assign trap     = in_valid && is_neg && lock_bad;

  always_comb begin
    if (is_byte)                    sz = SZ8;
    else if (long_mode && pfx_rexw) sz = SZ64;
    else if (pfx_opsz)              sz = SZ16;
    else                            sz = SZ32;
  end

  always_comb begin
    case (sz)
      SZ8:     mask = 64'h0000_0000_0000_00FF;
      SZ16:    mask = 64'h0000_0000_0000_FFFF;
      SZ32:    mask = 64'h0000_0000_FFFF_FFFF;
      default: mask = '1;
    endcase
  end

  assign opnd_m = operand & mask;
  assign res_m  = (64'd0 - opnd_m) & mask;

  always_comb begin
    case (sz)
      SZ8:     begin opnd_top = opnd_m[7];  res_top = res_m[7];  end
      SZ16:    begin opnd_top = opnd_m[15]; res_top = res_m[15]; end
      SZ32:    begin opnd_top = opnd_m[31]; res_top = res_m[31]; end
      default: begin opnd_top = opnd_m[63]; res_top = res_m[63]; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      ud_fault     <= 1'b0;
      result       <= '0;
      cf           <= 1'b0;
      of           <= 1'b0;
      sf           <= 1'b0;
      zf           <= 1'b0;
      af           <= 1'b0;
      pf           <= 1'b0;
      low_byte_sel <= 1'b0;
    end else begin
      out_valid <= take;
      ud_fault  <= trap;
      if (take) begin
        result       <= res_m;
        cf           <= |opnd_m;
        of           <= opnd_top && res_top;
        sf           <= res_top;
        zf           <= ~|res_m;
        af           <= |opnd_m[3:0];
        pf           <= ~^res_m[7:0];
        low_byte_sel <= is_byte && long_mode && pfx_rex && !dst_is_mem && rm_code[2];
      end
    end
  end

endmodule

module neg_exec_unit_props (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [7:0]  opcode,
  input logic [2:0]  modrm_reg,
  input logic        pfx_lock,
  input logic        dst_is_mem,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        cf,
  input logic        of,
  input logic        sf,
  input logic        zf,
  input logic        ud_fault
);

  a_r7_valid_after_request: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  a_r8_lock_reg_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == 8'hF6 || opcode == 8'hF7) && modrm_reg == 3'd3 && pfx_lock && !dst_is_mem)
    |=> (ud_fault && !out_valid));

  a_r8_fault_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault |-> !out_valid);

  a_r3_carry_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cf == (result != 64'd0)));

  a_r5_zero_vs_carry: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (zf == !cf));

  a_r4_overflow_negative: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && of) |-> (sf && cf));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(result) && $stable(cf) && $stable(zf)));

  a_r1_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(opcode == 8'hF6)) |-> (result[63:8] == 56'd0));

endmodule

bind neg_exec_unit neg_exec_unit_props u_props (.*);

// File: tb/neg_exec_unit_bench.sv
module neg_exec_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [2:0]  modrm_reg = 3'd0, rm_code = 3'd0;
  logic        pfx_rex = 0, pfx_rexw = 0, pfx_opsz = 0, pfx_lock = 0, long_mode = 0, dst_is_mem = 0;
  logic [63:0] operand = '0;
  logic        out_valid, cf, of, sf, zf, af, pf, ud_fault, low_byte_sel;
  logic [63:0] result;

  int total = 0, bad = 0;
  logic [63:0] lf = 64'h9E37_79B9_7F4A_7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  neg_exec_unit u_neg_exec_unit (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [7:0] opc, logic [2:0] ext, logic rex, logic rexw, logic opsz,
                       logic lock, logic lm, logic mem, logic [2:0] rm, logic [63:0] val);
    @(negedge clk);
    opcode = opc; modrm_reg = ext; pfx_rex = rex; pfx_rexw = rexw; pfx_opsz = opsz;
    pfx_lock = lock; long_mode = lm; dst_is_mem = mem; rm_code = rm; operand = val;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_neg(int w, logic [63:0] v, logic exp_low);
    logic [63:0] mask, vm, e;
    int ones;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    vm   = v & mask;
    e    = (mask - vm + 64'd1) & mask;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += e[i];
    chk("R7 out_valid", {63'd0, out_valid}, 64'd1);
    chk("R8 no fault", {63'd0, ud_fault}, 64'd0);
    chk("R1 result", result, e);
    chk("R3 cf", {63'd0, cf}, {63'd0, vm != 0});
    chk("R4 of", {63'd0, of}, {63'd0, vm == (64'd1 << (w-1))});
    if (vm == (64'd1 << (w-1))) chk("R4 result equals input", result, vm);
    chk("R5 sf", {63'd0, sf}, {63'd0, e[w-1]});
    chk("R5 zf", {63'd0, zf}, {63'd0, e == 0});
    chk("R6 af", {63'd0, af}, {63'd0, vm[3:0] != 0});
    chk("R6 pf", {63'd0, pf}, {63'd0, (ones % 2) == 0});
    chk("R10 low_byte_sel", {63'd0, low_byte_sel}, {63'd0, exp_low});
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] prev;
    logic        prev_cf;
    logic        c_rex[5], c_rexw[5], c_opsz[5], c_lm[5];
    int          c_w[5];
    c_rex  = '{0, 0, 1, 0, 1};
    c_rexw = '{0, 0, 1, 0, 1};
    c_opsz = '{1, 1, 0, 0, 1};
    c_lm   = '{0, 1, 0, 1, 1};
    c_w    = '{16, 16, 32, 32, 64};

    repeat (3) @(negedge clk);
    // R11: outputs cleared in reset
    chk("R11 reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R11 reset result", result, 64'd0);
    chk("R11 reset flags", {57'd0, cf, of, sf, zf, af, pf, ud_fault}, 64'd0);
    chk("R11 reset low_byte_sel", {63'd0, low_byte_sel}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 byte width: exhaustive sweep with junk above bit 7
    for (int v = 0; v < 256; v++) begin
      issue(8'hF6, 3'd3, 0, 0, 0, 0, v[0], 0, 3'd1, {56'hA5C3_0F96_5A3C_E1, v[7:0]});
      expect_neg(8, {56'd0, v[7:0]}, 1'b0);
    end

    // R2 wide widths and prefix priority
    for (int c = 0; c < 5; c++) begin
      for (int k = 0; k < 40; k++) begin
        logic [63:0] v;
        case (k)
          0: v = 64'd0;
          1: v = 64'd1;
          2: v = '1;
          3: v = 64'd1 << (c_w[c] - 1);
          4: v = (64'd1 << (c_w[c] - 1)) - 64'd1;
          5: v = 64'hFFFF_FFFF_FFFF_FF10;
          default: begin
            lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
            v = lf;
          end
        endcase
        issue(8'hF7, 3'd3, c_rex[c], c_rexw[c], c_opsz[c], 0, c_lm[c], k[0], 3'd2, v);
        expect_neg(c_w[c], v, 1'b0);
      end
    end

    // R10 low-byte indication
    for (int rm = 0; rm < 8; rm++) begin
      issue(8'hF6, 3'd3, 1, 0, 0, 0, 1, 0, rm[2:0], 64'h37);
      expect_neg(8, 64'h37, rm >= 4);
      issue(8'hF6, 3'd3, 0, 0, 0, 0, 1, 0, rm[2:0], 64'h37);
      expect_neg(8, 64'h37, 1'b0);
    end
    issue(8'hF6, 3'd3, 1, 0, 0, 0, 0, 0, 3'd5, 64'h80);
    expect_neg(8, 64'h80, 1'b0);
    issue(8'hF6, 3'd3, 1, 0, 0, 0, 1, 1, 3'd6, 64'h80);
    expect_neg(8, 64'h80, 1'b0);
    issue(8'hF7, 3'd3, 1, 0, 0, 0, 1, 0, 3'd6, 64'h80);
    expect_neg(32, 64'h80, 1'b0);

    // R8 LOCK with register destination
    issue(8'hF7, 3'd3, 0, 0, 0, 0, 1, 0, 3'd0, 64'h1234);
    prev = result; prev_cf = cf;
    issue(8'hF7, 3'd3, 0, 0, 0, 1, 1, 0, 3'd0, 64'd0);
    chk("R8 lock reg out_valid", {63'd0, out_valid}, 64'd0);
    chk("R8 lock reg ud_fault", {63'd0, ud_fault}, 64'd1);
    chk("R8 lock reg result held", result, prev);
    chk("R8 lock reg cf held", {63'd0, cf}, {63'd0, prev_cf});
    @(negedge clk);
    chk("R8 fault is a pulse", {63'd0, ud_fault}, 64'd0);
    issue(8'hF6, 3'd3, 0, 0, 0, 1, 0, 0, 3'd0, 64'h5);
    chk("R8 lock reg byte ud_fault", {63'd0, ud_fault}, 64'd1);
    chk("R8 lock reg byte result held", result, prev);
    // R8 LOCK with memory destination completes
    issue(8'hF7, 3'd3, 0, 0, 1, 1, 0, 1, 3'd0, 64'h8000);
    expect_neg(16, 64'h8000, 1'b0);

    // R9 non-negate requests ignored
    prev = result;
    for (int e = 0; e < 8; e++) begin
      if (e != 3) begin
        issue(8'hF7, e[2:0], 0, 0, 0, 0, 1, 0, 3'd0, 64'h77);
        chk("R9 other ext out_valid", {63'd0, out_valid}, 64'd0);
        chk("R9 other ext result", result, prev);
      end
    end
    issue(8'hF5, 3'd3, 0, 0, 0, 1, 1, 0, 3'd0, 64'h77);
    chk("R9 other opcode out_valid", {63'd0, out_valid}, 64'd0);
    chk("R9 other opcode ud_fault", {63'd0, ud_fault}, 64'd0);
    chk("R9 other opcode result", result, prev);

    // R7 single-cycle strobe
    issue(8'hF7, 3'd3, 0, 0, 0, 0, 0, 0, 3'd0, 64'h3);
    @(negedge clk);
    chk("R7 out_valid pulse ends", {63'd0, out_valid}, 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule